// File: doc/BRIEF.md
# Gray-Coded Read Pointer with Registered Empty Flag

This block is the read-clock half of a dual-clock FIFO. It keeps a binary read count and a Gray-coded copy of it. Both are one bit wider than the storage address, so a storage of 2^ADDR_W words uses ADDR_W+1 pointer bits. The Gray copy is exported to the write side. The lower ADDR_W bits of the binary count address the storage. The write side's Gray pointer arrives asynchronously. A two-flop synchronizer inside the block resamples it into the read clock.

The empty flag is registered. It is computed from the Gray value that the read pointer is about to load, compared against the synchronized write pointer. As a result, the flag falls or rises on the same edge on which the read pointer moves.

The consumer side works as a ready/valid pair. `empty` low plays the role of valid. `pop_req` plays the role of ready. A word is taken on a rising edge only when `pop_req` is high and `empty` is low. A `pop_req` while `empty` is high is back-pressured: it is dropped and nothing moves. The consumer need not hold `pop_req` in any particular way.

Top module: `gray_rd_side`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `empty` is 1, `rd_addr` is 0 and `rptr_gray` is 0.
- R2: A new write pointer value applied before rising edge k is reflected in `empty` after edge k+2 (two synchronizer stages plus the flag register), and not earlier.
- R3: A rising edge with `pop_req`=1 and `empty`=0 advances the read count by exactly one.
- R4: A rising edge with `pop_req`=1 and `empty`=1, or with `pop_req`=0, leaves `rd_addr` and `rptr_gray` unchanged.
- R5: `rptr_gray` equals g = b ^ (b >> 1), where b is the ADDR_W+1 bit binary read count. It changes in exactly one bit on each accepted pop.
- R6: After each edge, `empty` is 1 exactly when the read pointer just loaded equals the synchronized write pointer sampled on the previous edge, in all ADDR_W+1 bits. An accepted pop that reaches the write pointer raises `empty` on the same edge that moves `rd_addr`.
- R7: When the write count is ahead of the read count by exactly 2^ADDR_W, the two pointers differ in their upper bits, and `empty` stays 0.
- R8: `rd_addr` is the low ADDR_W bits of the binary read count. It wraps from 2^ADDR_W-1 to 0, and the hidden top bit of the count toggles at that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pop_req | input | 1 | Consumer ready: take one word if not empty |
| wptr_gray_async | input | ADDR_W+1 | Gray write pointer from the write clock domain |
| empty | output | 1 | Registered empty flag (low means a word is valid) |
| rd_addr | output | ADDR_W | Storage read address |
| rptr_gray | output | ADDR_W+1 | Gray read pointer exported to the write side |

## Verification
The read side is driven with sparse, balanced and dense pop patterns against a write pointer that moves randomly but never gets more than one storage depth ahead.
- The sparse pattern keeps the FIFO mostly full. It separates correct one-step advance from stalls.
- The dense pattern drives the FIFO into empty repeatedly. It shows whether blocked pops are really dropped and whether `empty` rises on the same edge as the final pop.
- A directed step of the write pointer on an empty FIFO measures the exact three-edge latency.
- A directed fill to exactly one full depth ahead shows that pointers differing only in their upper bits do not read as empty.
- Long runs wrap the counts many times, covering the address wrap and the top-bit toggle.

// File: rtl/gray_rd_pkg.sv
package gray_rd_pkg;

  localparam int unsigned CONV_W = 32;

  // Binary to reflected Gray code.
  function automatic logic [CONV_W-1:0] to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/rd_sync2.sv
module rd_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

endmodule

// File: rtl/rd_ptr_gen.sv
module rd_ptr_gen
  import gray_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q,
  output logic [PW-1:0] gray_next
);

  logic [PW-1:0] bin_next;

  always_comb begin
    bin_next  = bin_q + {{(PW-1){1'b0}}, advance};
    gray_next = PW'(to_gray(CONV_W'(bin_next)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_next;
      gray_q <= gray_next;
    end
  end

endmodule

// File: rtl/rd_empty_cmp.sv
module rd_empty_cmp #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] rgray_next,
  input  logic [PW-1:0] wgray_sync,
  output logic          empty_q
);

  logic match_all;

  // Every bit, including the wrap bit, must agree.
  assign match_all = (rgray_next == wgray_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= match_all;
  end

endmodule

// File: rtl/gray_rd_side.sv
module gray_rd_side #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic              clk_rd,
  input  logic              rst_n,
  input  logic              pop_req,
  input  logic [PW-1:0]     wptr_gray_async,
  output logic              empty,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PW-1:0]     rptr_gray
);

  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rbin;
  logic [PW-1:0] rgray_nx;
  logic          take;

  assign take = pop_req & ~empty;

  rd_sync2 #(.W(PW)) u_wsync (
    .clk     (clk_rd),
    .rst_n   (rst_n),
    .d_async (wptr_gray_async),
    .q_sync  (wgray_s)
  );

  rd_ptr_gen #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk_rd),
    .rst_n     (rst_n),
    .advance   (take),
    .bin_q     (rbin),
    .gray_q    (rptr_gray),
    .gray_next (rgray_nx)
  );

  rd_empty_cmp #(.PW(PW)) u_empty (
    .clk        (clk_rd),
    .rst_n      (rst_n),
    .rgray_next (rgray_nx),
    .wgray_sync (wgray_s),
    .empty_q    (empty)
  );

  assign rd_addr = rbin[ADDR_W-1:0];

endmodule

// File: rtl/gray_rd_side_chk.sv
module gray_rd_side_chk #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input logic              clk_rd,
  input logic              rst_n,
  input logic              pop_req,
  input logic              empty,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [PW-1:0]     rptr_gray
);

  logic [PW-1:0] gbin;

  always_comb begin
    gbin[PW-1] = rptr_gray[PW-1];
    for (int i = PW - 2; i >= 0; i--) gbin[i] = gbin[i+1] ^ rptr_gray[i];
  end

  assert_addr_step_R3: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (pop_req && !empty) |=> (rd_addr == $past(rd_addr) + 1'b1));

  assert_hold_blocked_R4: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (!pop_req || empty) |=> ($stable(rd_addr) && $stable(rptr_gray)));

  assert_gray_one_bit_R5: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (pop_req && !empty) |=> ($countones(rptr_gray ^ $past(rptr_gray)) == 1));

  assert_gray_addr_agree_R8: assert property (@(posedge clk_rd) disable iff (!rst_n)
    1'b1 |-> (gbin[ADDR_W-1:0] == rd_addr));

  assert_wrap_bit_R8: assert property (@(posedge clk_rd) disable iff (!rst_n)
    (pop_req && !empty && (rd_addr == {ADDR_W{1'b1}})) |=> (gbin[PW-1] != $past(gbin[PW-1])));

endmodule

bind gray_rd_side gray_rd_side_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_rd    (clk_rd),
  .rst_n     (rst_n),
  .pop_req   (pop_req),
  .empty     (empty),
  .rd_addr   (rd_addr),
  .rptr_gray (rptr_gray)
);

// File: tb/gray_rd_side_test.sv
`timescale 1ns/1ps
module gray_rd_side_test;

  localparam int AW    = 3;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          clk_rd = 1'b0;
  logic          rst_n  = 1'b0;
  logic          pop_req = 1'b0;
  logic [PW-1:0] wptr_gray_async = '0;
  logic          empty;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] rptr_gray;

  int total = 0;
  int bad   = 0;

  // bench-side reference state
  int            wtot = 0;     // writes issued, unbounded
  int            rtot = 0;     // reads accepted, unbounded
  logic [PW-1:0] m_s1 = '0, m_s2 = '0;
  logic          m_empty = 1'b1;
  logic [PW-1:0] prev_gray = '0;
  string         tag;

  gray_rd_side #(.ADDR_W(AW)) uut (
    .clk_rd          (clk_rd),
    .rst_n           (rst_n),
    .pop_req         (pop_req),
    .wptr_gray_async (wptr_gray_async),
    .empty           (empty),
    .rd_addr         (rd_addr),
    .rptr_gray       (rptr_gray)
  );

  always #2.5 clk_rd = ~clk_rd;

  function automatic logic [PW-1:0] gcode(input int n);
    logic [PW-1:0] b;
    b = PW'(n % (2 * DEPTH));
    return b ^ (b >> 1);
  endfunction

  task automatic check(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, predict, move to next negedge, compare.
  task automatic step(input logic pop);
    logic take;
    int   r_next;
    pop_req         = pop;
    wptr_gray_async = gcode(wtot);
    take   = pop && !m_empty;
    r_next = rtot + (take ? 1 : 0);
    tag    = take ? "R3" : (pop ? "R4" : "R4");
    @(posedge clk_rd);
    @(negedge clk_rd);
    m_empty = (gcode(r_next) == m_s2);
    m_s2    = m_s1;
    m_s1    = gcode(wtot);
    rtot    = r_next;
    check(rd_addr == AW'(rtot % DEPTH), {tag, "/R8 rd_addr"}, int'(rd_addr), rtot % DEPTH);
    check(rptr_gray == gcode(rtot), "R5 rptr_gray", int'(rptr_gray), int'(gcode(rtot)));
    check($countones(rptr_gray ^ prev_gray) == (take ? 1 : 0), "R5 one-bit step",
          $countones(rptr_gray ^ prev_gray), take ? 1 : 0);
    check(empty == m_empty, "R6 empty", int'(empty), int'(m_empty));
    prev_gray = rptr_gray;
  endtask

  task automatic sweep(input int cycles, input int pop_pct, input int wr_pct);
    for (int c = 0; c < cycles; c++) begin
      if ((wtot - rtot) < DEPTH && ($urandom % 100) < wr_pct) wtot++;
      step(($urandom % 100) < pop_pct);
    end
  endtask

  initial begin
    #500us;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_rd);
    // R1: held in reset
    check(empty == 1'b1, "R1 empty in reset", int'(empty), 1);
    check(rd_addr == '0, "R1 rd_addr in reset", int'(rd_addr), 0);
    check(rptr_gray == '0, "R1 rptr_gray in reset", int'(rptr_gray), 0);
    rst_n = 1'b1;
    step(1'b0);
    check(empty == 1'b1 && rd_addr == '0, "R1 first cycle after reset", int'(empty), 1);

    // R4: pops while empty are dropped
    for (int i = 0; i < 5; i++) step(1'b1);
    check(rd_addr == '0, "R4 pops while empty ignored", int'(rd_addr), 0);

    // R2: latency of one write step to empty
    wtot = 1;
    step(1'b0);
    check(empty == 1'b1, "R2 after 1 edge", int'(empty), 1);
    step(1'b0);
    check(empty == 1'b1, "R2 after 2 edges", int'(empty), 1);
    step(1'b0);
    check(empty == 1'b0, "R2 after 3 edges", int'(empty), 0);
    step(1'b1);
    check(empty == 1'b1 && rd_addr == AW'(1), "R6 final pop raises empty same edge",
          int'(empty), 1);

    // R7: exactly one depth ahead
    wtot = rtot + DEPTH;
    for (int i = 0; i < 4; i++) step(1'b0);
    check(empty == 1'b0, "R7 full-depth gap not empty", int'(empty), 0);
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1);
    check(empty == 1'b1, "R6 drained to empty", int'(empty), 1);
    check(rtot == 1 + DEPTH, "R8 wrap read count", rtot, 1 + DEPTH);

    // random sweeps at several densities
    sweep(1500, 20, 70);
    sweep(1500, 50, 50);
    sweep(1500, 90, 40);
    sweep(1500, 100, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule